// File: doc/BRIEF.md
# Two-Wire Serial Interface Status Flag Register

This block keeps the eight status flags of a two-wire serial interface controller. It does not shift bits, generate clocks or drive pins. The surrounding shift and bus logic sends it one-cycle event strobes, and it also sees the processor's read and write strobes for the status word and the two data buffers. Each strobe either sets or clears particular flags. Every flag has its own set rule, tied to a bus event or a buffer transfer.

Software clears a flag with a two-step handshake. It first reads the status word and sees the flag at 1, then writes 0 to that bit. A write of 0 without that earlier read changes nothing. Writing the transmit buffer or reading the receive buffer also clears the flags that belong to those buffers.

The same flag word serves the clocked-synchronous mode. In that mode only the overrun rule and the transmit-end rule differ. An interrupt request is raised whenever any flag is 1 and its matching enable bit is also 1.

Top module: `twi_status_flags`

## Requirements
- R1: The status word is `status[7:0]` with this bit layout: 7 = transmit-data-empty (TDE), 6 = transmit-end (TEND), 5 = receive-full (RDF), 4 = no-acknowledge (NACK), 3 = stop-seen (STOP), 2 = arbitration-lost / overrun (ALOV), 1 = own-address match (AMATCH), 0 = general-call (GCALL). After reset the word reads 0000X000 binary. Bit 3 is unspecified at reset, and a user must treat it as don't-care until a stop event has set it.
- R2: A write to the status word clears bit i only when two things hold: the write data bit i is 0, and bit i was read as 1 by a status read after the last status write. A write consumes every such earlier read. Writing 1, or writing 0 with no qualifying read, leaves the flag unchanged.
- R3: TDE sets on any of four strobes: transmit buffer moved to the shifter, transmit direction selected, start or repeated start generated, or slave receive changed to slave transmit. A transmit-buffer write clears TDE.
- R4: Outside clocked-synchronous mode, TEND sets on the ninth SCL clock when TDE is already 1. In clocked-synchronous mode, TEND sets when the last frame bit has been sent, and the ninth-clock strobe has no effect. A transmit-buffer write clears TEND.
- R5: RDF sets when the receive shifter loads the receive buffer. A receive-buffer read clears RDF.
- R6: Outside clocked-synchronous mode, ALOV sets in two cases. The first is an SDA mismatch at the SCL rising edge while the block is master and transmitting; a mismatch in any other mode has no effect. The second is a detected start while the block is master and SDA reads high.
- R7: In clocked-synchronous mode, ALOV signals overrun. It sets when the last bit of a new byte arrives while RDF is 1. If RDF is 0 when that bit arrives, ALOV does not set.
- R8: Outside clocked-synchronous mode, AMATCH sets on an address-match strobe only in slave receive mode, meaning neither master nor transmitting. GCALL sets on a general-call strobe whenever the block is not master.
- R9: Outside clocked-synchronous mode, NACK sets on a missing-acknowledge strobe only while acknowledge checking is enabled. STOP sets on a stop-after-frame strobe.
- R10: When a flag's set event and any of its clear conditions fall in the same cycle, the flag is 1 afterwards.
- R11: `irq` is 1 exactly when some bit of `status & irq_en` is 1. It is combinational, so it follows in the same cycle as the flags or the enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 = clocked-synchronous format |
| is_master | input | 1 | 1 = master mode |
| is_tx | input | 1 | 1 = transmit direction |
| ack_chk_en | input | 1 | Enables the missing-acknowledge flag |
| sda_in | input | 1 | Sampled SDA pin level |
| ev_txbuf_to_shift | input | 1 | Transmit buffer moved to the shifter |
| ev_dir_to_tx | input | 1 | Transmit direction selected |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_slv_rx_to_tx | input | 1 | Slave receive changed to slave transmit |
| ev_ninth_scl | input | 1 | Ninth SCL clock |
| ev_sync_last_tx | input | 1 | Last frame bit sent (synchronous mode) |
| ev_rxshift_to_buf | input | 1 | Receive shifter loaded the receive buffer |
| ev_sda_mismatch | input | 1 | Internal SDA differs from the pin at SCL rise |
| ev_start_seen | input | 1 | Start condition detected |
| ev_sync_last_rx | input | 1 | Last bit of a new byte received (synchronous mode) |
| ev_addr_hit | input | 1 | First frame matched the own address |
| ev_gcall_hit | input | 1 | General-call address seen |
| ev_no_ack | input | 1 | Receiver gave no acknowledge |
| ev_stop_seen | input | 1 | Stop condition after a frame |
| sts_rd | input | 1 | Status word read strobe |
| sts_wr | input | 1 | Status word write strobe |
| sts_wdata | input | 8 | Status write data |
| txd_wr | input | 1 | Transmit buffer write strobe |
| rxd_rd | input | 1 | Receive buffer read strobe |
| irq_en | input | 8 | Per-flag interrupt enables |
| status | output | 8 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
The flags are registered and the read-arming is hidden, so a wrong set or clear rule shows on `status` at the first clock edge after the event. A wrong arming state only shows later, when software writes 0 and a flag either clears when it should not or stays set when it should clear. For that reason the bench sends reads and writes in separate cycles, with events placed between them. The reference model is compared on every cycle, so a divergence is reported no more than one cycle after the strobe that caused it. A fault in the interrupt path shows in the same cycle as the flag or enable change.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;

  localparam int unsigned NFLAG    = 8;
  localparam int unsigned B_TDE    = 7;
  localparam int unsigned B_TEND   = 6;
  localparam int unsigned B_RDF    = 5;
  localparam int unsigned B_NACK   = 4;
  localparam int unsigned B_STOP   = 3;
  localparam int unsigned B_ALOV   = 2;
  localparam int unsigned B_AMATCH = 1;
  localparam int unsigned B_GCALL  = 0;

  typedef logic [NFLAG-1:0] flags_t;

  typedef struct packed {
    logic txbuf_to_shift;
    logic dir_to_tx;
    logic start_gen;
    logic slv_rx_to_tx;
    logic ninth_scl;
    logic sync_last_tx;
    logic rxshift_to_buf;
    logic sda_mismatch;
    logic start_seen;
    logic sync_last_rx;
    logic addr_hit;
    logic gcall_hit;
    logic no_ack;
    logic stop_seen;
  } twi_ev_t;

  typedef struct packed {
    logic sync_mode;
    logic is_master;
    logic is_tx;
    logic ack_chk_en;
    logic sda_in;
  } twi_mode_t;

  // set has priority over clear
  function automatic flags_t next_flags(flags_t q, flags_t set, flags_t clr);
    return set | (q & ~clr);
  endfunction

  // software clear: armed bits written as 0
  function automatic flags_t sw_clear(flags_t arm, flags_t wdata, logic wr);
    return {NFLAG{wr}} & arm & ~wdata;
  endfunction

  // a read arms the bits seen as 1; a write consumes all arming
  function automatic flags_t arm_update(flags_t arm, flags_t seen, logic rd,
                                        logic wr, flags_t flag_d);
    flags_t base;
    if (rd)      base = seen;
    else if (wr) base = '0;
    else         base = arm;
    return base & flag_d;
  endfunction

  function automatic logic irq_of(flags_t flags, flags_t en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/twi_stat_setgen.sv
module twi_stat_setgen
  import twi_stat_pkg::*;
(
  input  twi_ev_t   ev,
  input  twi_mode_t md,
  input  flags_t    flag_q,
  output flags_t    set_vec
);

  logic bus_fmt;
  logic slave_rx;
  logic master_tx;

  assign bus_fmt   = !md.sync_mode;
  assign slave_rx  = !md.is_master && !md.is_tx;
  assign master_tx = md.is_master && md.is_tx;

  always_comb begin
    set_vec = '0;
    set_vec[B_TDE]    = ev.txbuf_to_shift || ev.dir_to_tx ||
                        ev.start_gen || ev.slv_rx_to_tx;
    set_vec[B_TEND]   = bus_fmt ? (ev.ninth_scl && flag_q[B_TDE])
                                : ev.sync_last_tx;
    set_vec[B_RDF]    = ev.rxshift_to_buf;
    set_vec[B_NACK]   = bus_fmt && ev.no_ack && md.ack_chk_en;
    set_vec[B_STOP]   = bus_fmt && ev.stop_seen;
    set_vec[B_ALOV]   = bus_fmt
                        ? ((master_tx && ev.sda_mismatch) ||
                           (md.is_master && ev.start_seen && md.sda_in))
                        : (ev.sync_last_rx && flag_q[B_RDF]);
    set_vec[B_AMATCH] = bus_fmt && slave_rx && ev.addr_hit;
    set_vec[B_GCALL]  = bus_fmt && !md.is_master && ev.gcall_hit;
  end

endmodule

// File: rtl/twi_stat_arm.sv
module twi_stat_arm
  import twi_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sts_rd,
  input  logic   sts_wr,
  input  flags_t sts_wdata,
  input  flags_t flag_q,
  input  flags_t flag_d,
  output flags_t arm_q,
  output flags_t sw_clr
);

  flags_t arm_d;

  assign sw_clr = sw_clear(arm_q, sts_wdata, sts_wr);
  assign arm_d  = arm_update(arm_q, flag_q, sts_rd, sts_wr, flag_d);

  always_ff @(posedge clk) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end

endmodule

// File: rtl/twi_stat_bank.sv
module twi_stat_bank
  import twi_stat_pkg::*;
#(
  parameter int unsigned N         = NFLAG,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);

  assign flag_d = next_flags(flag_q, set_vec, clr_vec);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[i] <= RESET_VAL[i];
      else        flag_q[i] <= flag_d[i];
    end
  end

endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
  import twi_stat_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       is_master,
  input  logic       is_tx,
  input  logic       ack_chk_en,
  input  logic       sda_in,
  input  logic       ev_txbuf_to_shift,
  input  logic       ev_dir_to_tx,
  input  logic       ev_start_gen,
  input  logic       ev_slv_rx_to_tx,
  input  logic       ev_ninth_scl,
  input  logic       ev_sync_last_tx,
  input  logic       ev_rxshift_to_buf,
  input  logic       ev_sda_mismatch,
  input  logic       ev_start_seen,
  input  logic       ev_sync_last_rx,
  input  logic       ev_addr_hit,
  input  logic       ev_gcall_hit,
  input  logic       ev_no_ack,
  input  logic       ev_stop_seen,
  input  logic       sts_rd,
  input  logic       sts_wr,
  input  logic [7:0] sts_wdata,
  input  logic       txd_wr,
  input  logic       rxd_rd,
  input  logic [7:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);

  twi_ev_t   ev;
  twi_mode_t md;
  flags_t    set_vec;
  flags_t    clr_vec;
  flags_t    sw_clr;
  flags_t    buf_clr;
  flags_t    arm_q;
  flags_t    flag_q;
  flags_t    flag_d;

  assign ev = '{txbuf_to_shift: ev_txbuf_to_shift, dir_to_tx: ev_dir_to_tx,
                start_gen: ev_start_gen, slv_rx_to_tx: ev_slv_rx_to_tx,
                ninth_scl: ev_ninth_scl, sync_last_tx: ev_sync_last_tx,
                rxshift_to_buf: ev_rxshift_to_buf,
                sda_mismatch: ev_sda_mismatch, start_seen: ev_start_seen,
                sync_last_rx: ev_sync_last_rx, addr_hit: ev_addr_hit,
                gcall_hit: ev_gcall_hit, no_ack: ev_no_ack,
                stop_seen: ev_stop_seen};

  assign md = '{sync_mode: sync_mode, is_master: is_master, is_tx: is_tx,
                ack_chk_en: ack_chk_en, sda_in: sda_in};

  always_comb begin
    buf_clr         = '0;
    buf_clr[B_TDE]  = txd_wr;
    buf_clr[B_TEND] = txd_wr;
    buf_clr[B_RDF]  = rxd_rd;
  end

  assign clr_vec = sw_clr | buf_clr;

  twi_stat_setgen u_setgen (
    .ev      (ev),
    .md      (md),
    .flag_q  (flag_q),
    .set_vec (set_vec)
  );

  twi_stat_bank #(.N(NFLAG), .RESET_VAL(RESET_VAL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q),
    .flag_d  (flag_d)
  );

  twi_stat_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_rd    (sts_rd),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .flag_q    (flag_q),
    .flag_d    (flag_d),
    .arm_q     (arm_q),
    .sw_clr    (sw_clr)
  );

  assign status = flag_q;
  assign irq    = irq_of(flag_q, irq_en);

endmodule

// File: rtl/twi_stat_checker.sv
module twi_stat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       irq,
  input logic [7:0] irq_en,
  input logic [7:0] set_vec,
  input logic [7:0] clr_vec,
  input logic [7:0] arm_q,
  input logic       sts_wr,
  input logic       txd_wr,
  input logic       rxd_rd
);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((status & $past(set_vec)) == $past(set_vec)));

  p_fall_needs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~$past(clr_vec)) == 8'h00));

  p_unarmed_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && arm_q == 8'h00 && !txd_wr && !rxd_rd)
      |=> (($past(status) & ~status) == 8'h00));

  p_arm_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q & ~status) == 8'h00));

  p_txwr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !set_vec[7]) |=> !status[7]);

  p_rxrd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !set_vec[5]) |=> !status[5]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 8'h00) |-> !irq);

endmodule

bind twi_status_flags twi_stat_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status  (status),
  .irq     (irq),
  .irq_en  (irq_en),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .arm_q   (arm_q),
  .sts_wr  (sts_wr),
  .txd_wr  (txd_wr),
  .rxd_rd  (rxd_rd)
);

// File: tb/twi_status_flags_bench.sv
module twi_status_flags_bench;

  logic clk = 0;
  logic rst_n = 0;
  logic sync_mode = 0, is_master = 0, is_tx = 0, ack_chk_en = 0, sda_in = 0;
  logic ev_txbuf_to_shift = 0, ev_dir_to_tx = 0, ev_start_gen = 0;
  logic ev_slv_rx_to_tx = 0, ev_ninth_scl = 0, ev_sync_last_tx = 0;
  logic ev_rxshift_to_buf = 0, ev_sda_mismatch = 0, ev_start_seen = 0;
  logic ev_sync_last_rx = 0, ev_addr_hit = 0, ev_gcall_hit = 0;
  logic ev_no_ack = 0, ev_stop_seen = 0;
  logic sts_rd = 0, sts_wr = 0, txd_wr = 0, rxd_rd = 0;
  logic [7:0] sts_wdata = 8'hFF;
  logic [7:0] irq_en = 8'h00;
  logic [7:0] status;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twi_status_flags u_twi_status_flags (.*);

  // behavioural reference model
  bit m_f [8];
  bit m_arm [8];
  bit b3_known = 0;

  always @(posedge clk) begin
    bit s [8];
    bit c [8];
    bit nf [8];
    if (!rst_n) begin
      foreach (m_f[i]) begin m_f[i] = 0; m_arm[i] = 0; end
      b3_known = 0;
    end else begin
      foreach (s[i]) s[i] = 0;
      s[7] = ev_txbuf_to_shift | ev_dir_to_tx | ev_start_gen | ev_slv_rx_to_tx;
      s[5] = ev_rxshift_to_buf;
      if (sync_mode) begin
        s[6] = ev_sync_last_tx;
        s[2] = ev_sync_last_rx & m_f[5];
      end else begin
        s[6] = ev_ninth_scl & m_f[7];
        s[4] = ev_no_ack & ack_chk_en;
        s[3] = ev_stop_seen;
        if (is_master && is_tx && ev_sda_mismatch) s[2] = 1;
        if (is_master && ev_start_seen && sda_in) s[2] = 1;
        s[1] = !is_master & !is_tx & ev_addr_hit;
        s[0] = !is_master & ev_gcall_hit;
      end
      if (s[3]) b3_known = 1;
      for (int i = 0; i < 8; i++) begin
        c[i] = sts_wr & m_arm[i] & !sts_wdata[i];
        if ((i == 7 || i == 6) && txd_wr) c[i] = 1;
        if (i == 5 && rxd_rd) c[i] = 1;
        nf[i] = s[i] ? 1'b1 : (c[i] ? 1'b0 : m_f[i]);
      end
      for (int i = 0; i < 8; i++) begin
        if (sts_rd) m_arm[i] = m_f[i];
        else if (sts_wr) m_arm[i] = 0;
        m_arm[i] = m_arm[i] & nf[i];
        m_f[i] = nf[i];
      end
    end
  end

  function automatic string tag_of(int b);
    case (b)
      7: return "R3";
      6: return "R4";
      5: return "R5";
      4, 3: return "R9";
      2: return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    bit m_irq;
    if (rst_n && !done) begin
      m_irq = 0;
      for (int i = 0; i < 8; i++) begin
        if (i == 3 && !b3_known) continue;
        checks++;
        if (status[i] !== m_f[i]) begin
          failures++;
          $display("FAIL %s model bit %0d: actual=%b expected=%b", tag_of(i), i, status[i], m_f[i]);
        end
        if (m_f[i] && irq_en[i]) m_irq = 1;
      end
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R11 model irq: actual=%b expected=%b", irq, m_irq);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h mask=%h", tag, act, exp, mask);
    end
  endtask

  task automatic wipe();
    sts_rd = 1; tick(); sts_rd = 0;
    sts_wr = 1; sts_wdata = 8'h00; tick(); sts_wr = 0; sts_wdata = 8'hFF;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset word", status, 8'h00, 8'hF7);
    chk("R11 reset irq", {7'd0, irq}, 8'h00, 8'h01);

    // R3 set sources and buffer-write clear
    ev_txbuf_to_shift = 1; tick(); ev_txbuf_to_shift = 0;
    chk("R3 buf to shift", status, 8'h80, 8'h80);
    txd_wr = 1; tick(); txd_wr = 0;
    chk("R3 txd write clears", status, 8'h00, 8'h80);
    ev_dir_to_tx = 1; tick(); ev_dir_to_tx = 0;
    chk("R3 dir to tx", status, 8'h80, 8'h80);
    txd_wr = 1; tick(); txd_wr = 0;
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    chk("R3 start gen", status, 8'h80, 8'h80);
    txd_wr = 1; tick(); txd_wr = 0;
    ev_slv_rx_to_tx = 1; tick(); ev_slv_rx_to_tx = 0;
    chk("R3 slave rx to tx", status, 8'h80, 8'h80);

    // R4 transmit end
    ev_ninth_scl = 1; tick(); ev_ninth_scl = 0;
    chk("R4 ninth with TDE", status, 8'hC0, 8'hC0);
    txd_wr = 1; tick(); txd_wr = 0;
    chk("R4 txd write clears", status, 8'h00, 8'hC0);
    ev_ninth_scl = 1; tick(); ev_ninth_scl = 0;
    chk("R4 ninth without TDE", status, 8'h00, 8'h40);
    sync_mode = 1;
    ev_ninth_scl = 1; ev_txbuf_to_shift = 1; tick(); ev_txbuf_to_shift = 0;
    tick(); ev_ninth_scl = 0;
    chk("R4 ninth ignored in sync mode", status, 8'h80, 8'h40);
    ev_sync_last_tx = 1; tick(); ev_sync_last_tx = 0;
    chk("R4 sync last bit", status, 8'hC0, 8'h40);
    txd_wr = 1; tick(); txd_wr = 0;
    sync_mode = 0;

    // R5 receive full
    ev_rxshift_to_buf = 1; tick(); ev_rxshift_to_buf = 0;
    chk("R5 rx load", status, 8'h20, 8'h20);
    rxd_rd = 1; tick(); rxd_rd = 0;
    chk("R5 rx read clears", status, 8'h00, 8'h20);

    // R2 read-then-write-zero handshake
    ev_rxshift_to_buf = 1; tick(); ev_rxshift_to_buf = 0;
    sts_wr = 1; sts_wdata = 8'h00; tick(); sts_wr = 0;
    chk("R2 write0 without read", status, 8'h20, 8'h20);
    sts_rd = 1; tick(); sts_rd = 0;
    sts_wr = 1; sts_wdata = 8'hFF; tick(); sts_wr = 0;
    chk("R2 write1 no effect", status, 8'h20, 8'h20);
    sts_wr = 1; sts_wdata = 8'h00; tick(); sts_wr = 0;
    chk("R2 read consumed by write", status, 8'h20, 8'h20);
    sts_rd = 1; tick(); sts_rd = 0;
    sts_wr = 1; sts_wdata = 8'hDF; tick(); sts_wr = 0; sts_wdata = 8'hFF;
    chk("R2 armed write0 clears", status, 8'h00, 8'h20);
    sts_rd = 1; tick(); sts_rd = 0;
    ev_rxshift_to_buf = 1; tick(); ev_rxshift_to_buf = 0;
    sts_wr = 1; sts_wdata = 8'h00; tick(); sts_wr = 0;
    chk("R2 read as 0 does not arm", status, 8'h20, 8'h20);
    rxd_rd = 1; tick(); rxd_rd = 0;

    // R6 arbitration lost
    is_master = 1; is_tx = 1;
    ev_sda_mismatch = 1; tick(); ev_sda_mismatch = 0;
    chk("R6 master tx mismatch", status, 8'h04, 8'h04);
    wipe();
    chk("R6 cleared", status, 8'h00, 8'h04);
    is_tx = 0; sda_in = 1;
    ev_start_seen = 1; tick(); ev_start_seen = 0;
    chk("R6 start with SDA high", status, 8'h04, 8'h04);
    wipe();
    is_master = 0; is_tx = 1;
    ev_sda_mismatch = 1; tick(); ev_sda_mismatch = 0;
    chk("R6 mismatch as slave ignored", status, 8'h00, 8'h04);
    sda_in = 0; is_tx = 0;

    // R7 overrun
    sync_mode = 1;
    ev_sync_last_rx = 1; tick(); ev_sync_last_rx = 0;
    chk("R7 no overrun with RDF 0", status, 8'h00, 8'h04);
    ev_rxshift_to_buf = 1; tick(); ev_rxshift_to_buf = 0;
    ev_sync_last_rx = 1; tick(); ev_sync_last_rx = 0;
    chk("R7 overrun", status, 8'h24, 8'h24);
    rxd_rd = 1; tick(); rxd_rd = 0;
    wipe();
    sync_mode = 0;

    // R8 address match and general call
    ev_addr_hit = 1; tick(); ev_addr_hit = 0;
    chk("R8 slave rx address hit", status, 8'h02, 8'h02);
    wipe();
    is_master = 1;
    ev_addr_hit = 1; tick(); ev_addr_hit = 0;
    chk("R8 address hit as master ignored", status, 8'h00, 8'h02);
    is_master = 0;
    ev_gcall_hit = 1; tick(); ev_gcall_hit = 0;
    chk("R8 general call", status, 8'h01, 8'h01);
    wipe();

    // R9 no-acknowledge and stop
    ev_no_ack = 1; tick(); ev_no_ack = 0;
    chk("R9 nack with check off", status, 8'h00, 8'h10);
    ack_chk_en = 1;
    ev_no_ack = 1; tick(); ev_no_ack = 0;
    chk("R9 nack with check on", status, 8'h10, 8'h10);
    ev_stop_seen = 1; tick(); ev_stop_seen = 0;
    chk("R9 stop seen", status, 8'h18, 8'h18);
    wipe();
    chk("R9 cleared", status, 8'h00, 8'h18);

    // R10 set wins over clear
    ev_rxshift_to_buf = 1; tick(); ev_rxshift_to_buf = 0;
    sts_rd = 1; tick(); sts_rd = 0;
    sts_wr = 1; sts_wdata = 8'h00; ev_rxshift_to_buf = 1; rxd_rd = 1;
    tick(); sts_wr = 0; ev_rxshift_to_buf = 0; rxd_rd = 0; sts_wdata = 8'hFF;
    chk("R10 set beats clear", status, 8'h20, 8'h20);

    // R11 interrupt
    irq_en = 8'h20; #1;
    chk("R11 enabled flag raises irq", {7'd0, irq}, 8'h01, 8'h01);
    irq_en = 8'h5F; #1;
    chk("R11 other enables no irq", {7'd0, irq}, 8'h00, 8'h01);
    irq_en = 8'h00;
    tick(); tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule